// File: doc/BRIEF.md
# Multiplexer Connection and Lockout Controller

This controller decides when an upstream two-wire bus port may be joined to each of several downstream channels. After the primary supply becomes good it holds every channel switch, buffer and rise-time accelerator off for a fixed lockout window, and tells the pin logic to ignore bus transitions. The same window is started afresh whenever the secondary-supply comparator flag changes state, whichever way it moves.

Outside lockout, each synchronized enable input closes its own channel switch. Any number of channels may be closed together. The accelerator enable is raised whenever at least one channel is closed. When a stuck-bus fault arrives and disconnect mode is selected, every channel opens. The block then waits in a re-arm state until the fault has cleared and all enables have been seen low. Only after that can fresh enable assertions connect channels again. A bus that is already stuck at power-up is still connected once lockout ends, and stays connected until the fault timer upstream reports the fault.

Top module: `mux_link_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, every `chanConnect` bit is 0, `accelOn` is 0, `pinIgnore` is 1 and `rearmWait` is 0.
- R2: Lockout ends on the clock edge that samples the LOCK_TICKS-th `tick` pulse while `supplyOk` is high. Before that edge every `chanConnect` bit stays 0, whatever the enables are.
- R3: While `supplyOk` is low the block is in lockout with its tick count cleared. A drop during lockout therefore restarts the full LOCK_TICKS window.
- R4: Any change of `auxAbove`, from 0 to 1 or from 1 to 0, puts the block into lockout and restarts the full LOCK_TICKS window from any state.
- R5: Outside lockout and re-arm, `chanConnect[i]` follows `enPins[i]` through a two-flop synchronizer and one output register. Any combination of channels may be connected at once.
- R6: `accelOn` is 1 exactly when at least one `chanConnect` bit is 1.
- R7: `pinIgnore` is 1 exactly while the block is in lockout.
- R8: If `faultFlag` is 1 while `discSel` is 1 and channels are running, all `chanConnect` bits go to 0 and `rearmWait` goes to 1. They stay so until `faultFlag` is 0 and all synchronized enables are 0 in the same cycle.
- R9: If `faultFlag` is 1 while `discSel` is 0, the connections are unchanged and `rearmWait` stays 0.
- R10: In re-arm, re-asserting enables while `faultFlag` is still 1, or without first dropping all enables, connects no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOk | input | 1 | Primary supply good |
| auxAbove | input | 1 | Secondary supply comparator output |
| tick | input | 1 | One-cycle timebase pulse |
| enPins | input | NUM_CH | Per-channel enable requests (asynchronous) |
| faultFlag | input | 1 | Stuck-bus fault reported |
| discSel | input | 1 | 1 = disconnect and re-arm on fault |
| chanConnect | output | NUM_CH | Per-channel switch enable |
| accelOn | output | 1 | Buffer and accelerator enable |
| pinIgnore | output | 1 | Bus pin transitions to be ignored |
| rearmWait | output | 1 | Waiting for the all-enables-low re-arm |

## Verification
Several properties are checked on every cycle:
- a low supply forces lockout with a cleared count;
- a comparator crossing forces lockout;
- a disconnect-mode fault moves running channels into re-arm;
- re-arm holds while its exit condition is missing;
- no channel closes the cycle after the switches were not allowed to pass;
- a connected channel was always requested.

The exact length of the lockout window, its restart after a supply drop or a crossing in each direction, the mapping of all enable patterns to channels, and the complete fault, release and re-arm sequence can only be shown by the bench's scenarios.

// File: rtl/link_ctrl_pkg.sv
package link_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REARM = 2'd2
  } linkState_e;

  typedef struct packed {
    logic passEn;
  } linkStrobe_t;
endpackage

// File: rtl/link_lockout_ctrl.sv
module link_lockout_ctrl
  import link_ctrl_pkg::*;
#(
  parameter int LOCK_TICKS = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        auxAbove,
  input  logic        tick,
  input  logic        faultFlag,
  input  logic        discSel,
  input  logic        allLow,
  output linkStrobe_t strobe,
  output logic        pinIgnore,
  output logic        rearmWait
);
  localparam int CW = $clog2(LOCK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

  linkState_e state, stateNext;
  logic [CW-1:0] tickCnt, tickCntNext;
  logic auxPrev;
  logic auxCross;

  assign auxCross = auxAbove ^ auxPrev;

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    if (!supplyOk || auxCross) begin
      stateNext   = ST_LOCK;
      tickCntNext = '0;
    end else begin
      unique case (state)
        ST_LOCK: if (tick) begin
          if (tickCnt == LAST) begin
            stateNext   = ST_RUN;
            tickCntNext = '0;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
        ST_RUN:   if (faultFlag && discSel) stateNext = ST_REARM;
        ST_REARM: if (allLow && !faultFlag) stateNext = ST_RUN;
        default:  stateNext = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LOCK;
      tickCnt <= '0;
      auxPrev <= auxAbove;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      auxPrev <= auxAbove;
    end
  end

  assign strobe.passEn = (state == ST_RUN);
  assign pinIgnore     = (state == ST_LOCK);
  assign rearmWait     = (state == ST_REARM);

  // R3: a low supply forces lockout with a cleared count
  assert_supply_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == ST_LOCK) && (tickCnt == '0));

  // R4: a comparator crossing forces lockout
  assert_cross_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (auxAbove != auxPrev) |=> (state == ST_LOCK) && (tickCnt == '0));

  // R8: a disconnect-mode fault moves running channels into re-arm
  assert_fault_rearm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && faultFlag && discSel && supplyOk && !auxCross
      |=> rearmWait);

  // R8: re-arm holds while its exit condition is missing
  assert_rearm_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARM) && supplyOk && !auxCross && !(allLow && !faultFlag)
      |=> rearmWait);
endmodule

// File: rtl/link_chan_path.sv
module link_chan_path
  import link_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] enPins,
  input  linkStrobe_t       strobe,
  output logic              allLow,
  output logic [NUM_CH-1:0] chanConnect,
  output logic              accelOn
);
  logic [NUM_CH-1:0] syncA, syncEn, connectQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[ch]    <= 1'b0;
        syncEn[ch]   <= 1'b0;
        connectQ[ch] <= 1'b0;
      end else begin
        syncA[ch]    <= enPins[ch];
        syncEn[ch]   <= syncA[ch];
        connectQ[ch] <= strobe.passEn & syncEn[ch];
      end
    end
  end

  assign allLow      = ~|syncEn;
  assign chanConnect = connectQ;
  assign accelOn     = |connectQ;

  // R2: no channel closes the cycle after the switches were not allowed to pass
  assert_no_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.passEn |=> (chanConnect == '0));

  // R5: a connected channel was always requested
  assert_connect_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((chanConnect & ~$past(syncEn)) == '0));
endmodule

// File: rtl/mux_link_ctrl.sv
module mux_link_ctrl
  import link_ctrl_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int LOCK_TICKS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              auxAbove,
  input  logic              tick,
  input  logic [NUM_CH-1:0] enPins,
  input  logic              faultFlag,
  input  logic              discSel,
  output logic [NUM_CH-1:0] chanConnect,
  output logic              accelOn,
  output logic              pinIgnore,
  output logic              rearmWait
);
  linkStrobe_t strobe;
  logic allLow;

  link_lockout_ctrl #(.LOCK_TICKS(LOCK_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .auxAbove(auxAbove),
    .tick(tick), .faultFlag(faultFlag), .discSel(discSel), .allLow(allLow),
    .strobe(strobe), .pinIgnore(pinIgnore), .rearmWait(rearmWait)
  );

  link_chan_path #(.NUM_CH(NUM_CH)) u_path (
    .clk(clk), .rstN(rstN), .enPins(enPins), .strobe(strobe),
    .allLow(allLow), .chanConnect(chanConnect), .accelOn(accelOn)
  );
endmodule

// File: tb/tb_mux_link_ctrl.sv
`timescale 1ns/1ps
module tb_mux_link_ctrl;
  localparam int NCH = 4;
  localparam int LT  = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, auxAbove = 1'b0, tick = 1'b0, faultFlag = 1'b0, discSel = 1'b1;
  logic [NCH-1:0] enPins = '0;
  logic [NCH-1:0] chanConnect;
  logic accelOn, pinIgnore, rearmWait;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  mux_link_ctrl #(.NUM_CH(NCH), .LOCK_TICKS(LT)) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .auxAbove(auxAbove), .tick(tick),
    .enPins(enPins), .faultFlag(faultFlag), .discSel(discSel),
    .chanConnect(chanConnect), .accelOn(accelOn), .pinIgnore(pinIgnore),
    .rearmWait(rearmWait)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; waitCyc(2);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int conn, input int ign, input int rearm);
    check(req, int'(chanConnect), conn);
    check(req, int'(accelOn), int'(conn != 0));
    check(req, int'(pinIgnore), ign);
    check(req, int'(rearmWait), rearm);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    checkOut("R1 reset", 0, 1, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 0, 1, 0);

    // R2: lockout length, enables all high throughout
    enPins = '1;
    supplyOk = 1'b1;
    waitCyc(2);
    pulseTicks(LT - 1);
    checkOut("R2 before window end", 0, 1, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R7 lockout over", int'(pinIgnore), 0);
    waitCyc(2);
    checkOut("R5 all channels", 15, 0, 0);

    // R5/R6: sweep every enable pattern
    for (int p = 0; p < 16; p++) begin
      enPins = NCH'(p);
      waitCyc(4);
      checkOut("R5 R6 pattern", p, 0, 0);
    end

    // R3: supply drop during lockout restarts the window
    supplyOk = 1'b0; waitCyc(1); supplyOk = 1'b1; waitCyc(1);
    checkOut("R3 supply drop", 0, 1, 0);
    pulseTicks(5);
    supplyOk = 1'b0; waitCyc(1); supplyOk = 1'b1; waitCyc(1);
    pulseTicks(LT - 1);
    checkOut("R3 restarted window", 0, 1, 0);
    pulseTicks(1);
    checkOut("R3 window done", 15, 0, 0);

    // R4: rising crossing
    enPins = 4'b0110;
    waitCyc(4);
    auxAbove = 1'b1; waitCyc(2);
    checkOut("R4 rising crossing", 0, 1, 0);
    pulseTicks(LT);
    checkOut("R4 after rising", 6, 0, 0);
    // R4: falling crossing in the middle of a new window
    auxAbove = 1'b0; waitCyc(2);
    pulseTicks(4);
    auxAbove = 1'b1; waitCyc(2);
    pulseTicks(LT - 1);
    checkOut("R4 restarted by crossing", 0, 1, 0);
    pulseTicks(1);
    checkOut("R4 window done", 6, 0, 0);

    // R9: fault without disconnect leaves channels alone
    discSel = 1'b0; faultFlag = 1'b1; waitCyc(4);
    checkOut("R9 fault no disconnect", 6, 0, 0);
    faultFlag = 1'b0; discSel = 1'b1; waitCyc(2);

    // R8: fault with disconnect
    enPins = 4'b0101; waitCyc(4);
    faultFlag = 1'b1; waitCyc(3);
    checkOut("R8 disconnected", 0, 0, 1);
    // R10: enables low but fault still high keeps re-arm
    enPins = '0; waitCyc(4);
    enPins = 4'b0101; waitCyc(4);
    checkOut("R10 fault still set", 0, 0, 1);
    // R10: fault cleared but enables never dropped
    faultFlag = 1'b0; waitCyc(4);
    checkOut("R10 enables not dropped", 0, 0, 1);
    enPins = '0; waitCyc(4);
    checkOut("R8 re-armed", 0, 0, 0);
    enPins = 4'b1001; waitCyc(4);
    checkOut("R8 reconnected", 9, 0, 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule